// File: doc/BRIEF.md
# Buffered I2C Master Transfer Engine

This block runs the byte level of an I2C master. Software fills a 32-byte word-packed transmit buffer, programs a few configuration registers and then writes a byte count to launch a chunk. The engine walks through the chunk and hands each bus bit to an external SCL timing generator as a request. The generator answers each request with an acknowledge pulse and, on receive bits, the sampled SDA value. Received bytes land in a matching word-packed receive buffer.

The block has three modes. Transmit mode sends the buffer contents as they are, so software places the device address in byte 0. Register-read mode sends the write address and up to three register-address bytes, then a repeated START and the read address, and then clocks in the data. Continuation mode reads one more chunk with no START and no address. Three pending flags report the end of a transmit chunk, the end of a receive chunk and an aborting NACK. Each flag can drive the interrupt output.

Between chunks the engine issues no bit requests, so the timing generator keeps SCL low until the next count is written.

Top module: `i2cm_engine`

## Requirements
- R1: After reset, `pend_o` is 0, `irq_o` is 0 and `bit_req_o` is 0.
- R2: Register map on `reg_addr_i`: 0 control, 1 read address, 2 register address, 3 transmit count, 4 receive count, 5 interrupt enable, 6 pending (write 1 to clear), 8 to 15 transmit words 0 to 7. With control bit 0 (enable) set and bits 2:1 (mode) equal to 0 (transmit), writing a nonzero count (bits 5:0, values above 32 treated as 32) to the transmit count register sends that many buffer bytes. Byte k comes from word k/4, bits 8*(k%4)+7 down to 8*(k%4). Each byte goes out MSB first as eight SEND requests and is followed by one RECV request for the acknowledge. At the end, pending bit 0 is set.
- R3: A transmit chunk starts with one START request only when control bit 3 was written as 1 since the previous launch. `bit_op_o` encodes START=0, SEND=1 and RECV=2.
- R4: With mode 1 (register read), writing the receive count issues START. If the register-address count (register 2, bits 25:24) is nonzero, the engine then sends the write address (register 1, bits 7:0, with bit 0 cleared), then that many bytes from register 2 bits 23:0, lowest byte first, and then a repeated START. It then sends the read address (register 1, bits 7:0) and receives the programmed count of bytes.
- R5: In mode 1, a receive-count write is ignored while the valid bit (register 1, bit 8) is 0.
- R6: With mode 2 (continuation), writing the receive count only receives bytes, with no START and no address. Each received byte is made of eight RECV bits, MSB first. Received byte k is stored in receive word k/4 at bit offset 8*(k%4), readable through `rx_sel_i`/`rx_word_o`. At the end of the chunk, pending bit 1 is set.
- R7: After each received byte the engine drives one SEND request carrying the acknowledge: 0 (ACK) for every byte except the last of the chunk. The last byte gets the value of control bit 4, where 1 means NACK.
- R8: With control bit 5 (NAK abort) set, a RECV acknowledge of 1 after any sent byte sets pending bit 2, stops the chunk with no further requests, and leaves bits 0 and 1 unchanged.
- R9: With control bit 5 clear, a NACK on a sent byte does not stop the chunk.
- R10: A control write with bit 0 equal to 0 aborts any chunk in progress, drops `bit_req_o` and disables the engine, so later count writes start nothing.
- R11: `irq_o` is 1 exactly when some pending bit and its enable bit (register 5, same position) are both 1. Writing 1 to a bit of register 6 clears that pending bit.
- R12: After a chunk ends, `bit_req_o` stays 0 until the next launch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| rx_sel_i | input | 3 | Receive word select |
| rx_word_o | output | 32 | Selected receive word |
| pend_o | output | 3 | Pending flags: 0 transmit done, 1 receive done, 2 NACK abort |
| irq_o | output | 1 | Interrupt request |
| bit_req_o | output | 1 | Bit request to the timing generator |
| bit_op_o | output | 2 | Bit operation: 0 START, 1 SEND, 2 RECV |
| bit_val_o | output | 1 | Bit value for SEND |
| bit_ack_i | input | 1 | Generator has completed the current bit |
| bit_rd_i | input | 1 | Sampled SDA for RECV, valid with `bit_ack_i` |

## Verification
A wrong phase or byte index shows up within one bit request. A skipped or extra START, a register byte sent in the wrong order, or a misplaced acknowledge slot changes the logged bit stream at that exact position, so the bench compares every bit the engine requests against a stream built from the register values. A wrong bit counter or a bad buffer lane shows up in the SEND values or in the receive words read back after the chunk. A fault in the abort or hold logic shows up as a bit request after the chunk should have ended. Count and mode sweeps cover the chunk lengths 1 to 32, the clamp, and every register-address length.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    typedef enum logic [1:0] {OP_START = 2'd0, OP_SEND = 2'd1, OP_RECV = 2'd2} bit_op_e;
    typedef enum logic [1:0] {K_START = 2'd0, K_WRITE = 2'd1, K_READ = 2'd2} byte_kind_e;
    typedef enum logic [1:0] {MD_TX = 2'd0, MD_TRX = 2'd1, MD_RX = 2'd2} mode_e;
    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_WADDR, ST_REG, ST_RSTART, ST_RADDR, ST_DATA
    } phase_e;

    localparam int A_CTRL  = 0;
    localparam int A_RADDR = 1;
    localparam int A_RREG  = 2;
    localparam int A_TXCNT = 3;
    localparam int A_RXCNT = 4;
    localparam int A_IEN   = 5;
    localparam int A_PEND  = 6;

    localparam int PF_TX  = 0;
    localparam int PF_RX  = 1;
    localparam int PF_NAK = 2;
    localparam int NFLAGS = 3;
endpackage

// File: rtl/i2cm_byte_shifter.sv
module i2cm_byte_shifter
    import i2cm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       go_i,
    input  byte_kind_e kind_i,
    input  logic [7:0] tx_byte_i,
    input  logic       ack_val_i,
    output logic       busy_o,
    output logic       done_o,
    output logic [7:0] rx_byte_o,
    output logic       nak_o,
    output logic       bit_req_o,
    output logic [1:0] bit_op_o,
    output logic       bit_val_o,
    input  logic       bit_ack_i,
    input  logic       bit_rd_i
);
    typedef struct packed {
        logic       busy;
        byte_kind_e kind;
        logic [3:0] cnt;
        logic [7:0] sh;
        logic       ackv;
    } sh_state_t;

    sh_state_t q, d;
    logic step, last;

    always_comb begin
        d      = q;
        step   = q.busy && bit_ack_i;
        last   = (q.kind == K_START) || (q.cnt == 4'd8);
        done_o = step && last;
        if (clr_i) begin
            d.busy = 1'b0;
        end else if (step) begin
            if (last) begin
                d.busy = 1'b0;
            end else begin
                d.cnt = q.cnt + 4'd1;
                d.sh  = {q.sh[6:0], (q.kind == K_READ) ? bit_rd_i : 1'b0};
            end
        end else if (go_i && !q.busy) begin
            d.busy = 1'b1;
            d.kind = kind_i;
            d.cnt  = 4'd0;
            d.sh   = tx_byte_i;
            d.ackv = ack_val_i;
        end
    end

    always_comb begin
        unique case (q.kind)
            K_START: bit_op_o = OP_START;
            K_WRITE: bit_op_o = (q.cnt == 4'd8) ? OP_RECV : OP_SEND;
            default: bit_op_o = (q.cnt == 4'd8) ? OP_SEND : OP_RECV;
        endcase
        if (q.kind == K_READ) bit_val_o = q.ackv;
        else                  bit_val_o = (q.kind == K_WRITE) && q.sh[7];
    end

    assign busy_o    = q.busy;
    assign bit_req_o = q.busy;
    assign rx_byte_o = q.sh;
    assign nak_o     = bit_rd_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R2
    bit_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> (q.cnt <= 4'd8));

    // R2
    op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_req_o && !bit_ack_i && !clr_i) |=> (bit_req_o && $stable(bit_op_o)));
endmodule

// File: rtl/i2cm_word_buf.sv
module i2cm_word_buf #(
    parameter int WORDS = 8,
    parameter int IDXW  = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   word_we_i,
    input  logic [IDXW-3:0]        word_idx_i,
    input  logic [31:0]            word_i,
    input  logic                   byte_we_i,
    input  logic [IDXW-1:0]        byte_idx_i,
    input  logic [7:0]             byte_i,
    output logic [WORDS-1:0][31:0] words_o
);
    localparam int WSELW = IDXW - 2;

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [31:0] word_d, word_q;
        always_comb begin
            word_d = word_q;
            if (word_we_i && (word_idx_i == WSELW'(w)))
                word_d = word_i;
            else if (byte_we_i && (byte_idx_i[IDXW-1:2] == WSELW'(w)))
                word_d[{byte_idx_i[1:0], 3'b000} +: 8] = byte_i;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) word_q <= '0;
            else        word_q <= word_d;
        end
        assign words_o[w] = word_q;
    end
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
    import i2cm_pkg::*;
#(
    parameter int WORDS = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_we_i,
    input  logic [$clog2(WORDS):0]     reg_addr_i,
    input  logic [31:0]                reg_wdata_i,
    input  logic [$clog2(WORDS)-1:0]   rx_sel_i,
    output logic [31:0]                rx_word_o,
    output logic [2:0]                 pend_o,
    output logic                       irq_o,
    output logic                       bit_req_o,
    output logic [1:0]                 bit_op_o,
    output logic                       bit_val_o,
    input  logic                       bit_ack_i,
    input  logic                       bit_rd_i
);
    localparam int BYTES = WORDS * 4;
    localparam int IDXW  = $clog2(BYTES);
    localparam int CNTW  = IDXW + 1;
    localparam int WSELW = IDXW - 2;
    localparam int ADDRW = WSELW + 1;

    typedef struct packed {
        logic              en;
        logic [1:0]        mode;
        logic              start_pend;
        logic              last_nack;
        logic              nak_abort;
        logic [7:0]        raddr;
        logic              rvalid;
        logic [23:0]       rreg;
        logic [1:0]        rcnt;
        logic [NFLAGS-1:0] ien;
        logic [NFLAGS-1:0] pend;
        phase_e            phase;
        logic [IDXW-1:0]   idx;
        logic [CNTW-1:0]   len;
        logic              rx;
    } eng_state_t;

    eng_state_t q, d;

    logic [WORDS-1:0][31:0] tx_words, rx_words;
    logic       sh_go, sh_clr, sh_busy, sh_done, sh_nak, sh_ackv;
    byte_kind_e sh_kind;
    logic [7:0] sh_tx, sh_rx;
    logic       rx_we, buf_wr, ctrl_wr;
    logic       idx_last, abort;
    logic [CNTW-1:0] cnt_req;

    function automatic logic [CNTW-1:0] clamp_cnt(input logic [CNTW-1:0] c);
        return (c > CNTW'(BYTES)) ? CNTW'(BYTES) : c;
    endfunction

    assign buf_wr   = reg_we_i && reg_addr_i[ADDRW-1];
    assign ctrl_wr  = reg_we_i && (reg_addr_i == ADDRW'(A_CTRL));
    assign sh_clr   = ctrl_wr && !reg_wdata_i[0];
    assign cnt_req  = clamp_cnt(reg_wdata_i[CNTW-1:0]);
    assign idx_last = (CNTW'(q.idx) == q.len - CNTW'(1));

    // what the shifter is told to do in the current phase
    always_comb begin
        sh_go   = (q.phase != ST_IDLE) && !sh_busy;
        sh_ackv = idx_last && q.last_nack;
        sh_tx   = 8'h00;
        unique case (q.phase)
            ST_START, ST_RSTART: sh_kind = K_START;
            ST_DATA:             sh_kind = q.rx ? K_READ : K_WRITE;
            default:             sh_kind = K_WRITE;
        endcase
        unique case (q.phase)
            ST_WADDR: sh_tx = {q.raddr[7:1], 1'b0};
            ST_REG:   sh_tx = q.rreg[{q.idx[1:0], 3'b000} +: 8];
            ST_RADDR: sh_tx = q.raddr;
            ST_DATA:  sh_tx = tx_words[q.idx[IDXW-1:2]][{q.idx[1:0], 3'b000} +: 8];
            default:  sh_tx = 8'h00;
        endcase
        rx_we = sh_done && (q.phase == ST_DATA) && q.rx;
        abort = sh_done && (sh_kind == K_WRITE) && sh_nak && q.nak_abort;
    end

    always_comb begin
        d = q;
        // configuration registers
        if (reg_we_i && !reg_addr_i[ADDRW-1]) begin
            if (reg_addr_i == ADDRW'(A_RADDR)) begin
                d.raddr  = reg_wdata_i[7:0];
                d.rvalid = reg_wdata_i[8];
            end
            if (reg_addr_i == ADDRW'(A_RREG)) begin
                d.rreg = reg_wdata_i[23:0];
                d.rcnt = reg_wdata_i[25:24];
            end
            if (reg_addr_i == ADDRW'(A_IEN))  d.ien  = reg_wdata_i[NFLAGS-1:0];
            if (reg_addr_i == ADDRW'(A_PEND)) d.pend = q.pend & ~reg_wdata_i[NFLAGS-1:0];
            if (reg_addr_i == ADDRW'(A_TXCNT) && q.en && q.mode == MD_TX &&
                q.phase == ST_IDLE && cnt_req != '0) begin
                d.len        = cnt_req;
                d.idx        = '0;
                d.rx         = 1'b0;
                d.phase      = q.start_pend ? ST_START : ST_DATA;
                d.start_pend = 1'b0;
            end
            if (reg_addr_i == ADDRW'(A_RXCNT) && q.en && q.phase == ST_IDLE &&
                cnt_req != '0 &&
                (q.mode == MD_RX || (q.mode == MD_TRX && q.rvalid))) begin
                d.len   = cnt_req;
                d.idx   = '0;
                d.rx    = 1'b1;
                d.phase = (q.mode == MD_TRX) ? ST_START : ST_DATA;
            end
        end
        // phase sequencing on each completed byte
        if (sh_done) begin
            unique case (q.phase)
                ST_START:  d.phase = !q.rx ? ST_DATA :
                                     (q.rcnt != 2'd0) ? ST_WADDR : ST_RADDR;
                ST_WADDR: begin
                    d.phase = ST_REG;
                    d.idx   = '0;
                end
                ST_REG: begin
                    if (q.idx[1:0] == q.rcnt - 2'd1) begin
                        d.phase = ST_RSTART;
                        d.idx   = '0;
                    end else begin
                        d.idx = q.idx + IDXW'(1);
                    end
                end
                ST_RSTART: d.phase = ST_RADDR;
                ST_RADDR: begin
                    d.phase = ST_DATA;
                    d.idx   = '0;
                end
                ST_DATA: begin
                    if (idx_last) begin
                        d.phase = ST_IDLE;
                        if (q.rx) d.pend[PF_RX] = 1'b1;
                        else      d.pend[PF_TX] = 1'b1;
                    end else begin
                        d.idx = q.idx + IDXW'(1);
                    end
                end
                default: d.phase = ST_IDLE;
            endcase
            if (abort) begin
                d.phase        = ST_IDLE;
                d.pend         = q.pend;
                d.pend[PF_NAK] = 1'b1;
            end
        end
        // control register last: a disable write wins over everything
        if (ctrl_wr) begin
            if (!reg_wdata_i[0]) begin
                d.en         = 1'b0;
                d.phase      = ST_IDLE;
                d.start_pend = 1'b0;
                d.idx        = '0;
            end else begin
                d.en         = 1'b1;
                d.mode       = reg_wdata_i[2:1];
                d.start_pend = q.start_pend | reg_wdata_i[3];
                d.last_nack  = reg_wdata_i[4];
                d.nak_abort  = reg_wdata_i[5];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    i2cm_word_buf #(.WORDS(WORDS), .IDXW(IDXW)) u_txbuf (
        .clk, .rst_n,
        .word_we_i (buf_wr),
        .word_idx_i(reg_addr_i[WSELW-1:0]),
        .word_i    (reg_wdata_i),
        .byte_we_i (1'b0),
        .byte_idx_i('0),
        .byte_i    (8'h00),
        .words_o   (tx_words)
    );

    i2cm_word_buf #(.WORDS(WORDS), .IDXW(IDXW)) u_rxbuf (
        .clk, .rst_n,
        .word_we_i (1'b0),
        .word_idx_i('0),
        .word_i    (32'h0),
        .byte_we_i (rx_we),
        .byte_idx_i(q.idx),
        .byte_i    (sh_rx),
        .words_o   (rx_words)
    );

    i2cm_byte_shifter u_shift (
        .clk, .rst_n,
        .clr_i    (sh_clr),
        .go_i     (sh_go),
        .kind_i   (sh_kind),
        .tx_byte_i(sh_tx),
        .ack_val_i(sh_ackv),
        .busy_o   (sh_busy),
        .done_o   (sh_done),
        .rx_byte_o(sh_rx),
        .nak_o    (sh_nak),
        .bit_req_o,
        .bit_op_o,
        .bit_val_o,
        .bit_ack_i,
        .bit_rd_i
    );

    assign rx_word_o = rx_words[rx_sel_i];
    assign pend_o    = q.pend;
    assign irq_o     = |(q.pend & q.ien);

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == ST_IDLE) |-> !bit_req_o);

    // R10
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q.en |-> !bit_req_o);

    // R8
    nak_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.pend[PF_NAK]) |-> !bit_req_o);

    // R2
    tx_done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.pend[PF_TX]) |-> ($past(q.phase) == ST_DATA));
endmodule

// File: tb/tb_i2cm_engine.sv
module tb_i2cm_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [2:0]  rx_sel = '0;
    logic [31:0] rx_word;
    logic [2:0]  pend;
    logic        irq;
    logic        bit_req;
    logic [1:0]  bit_op;
    logic        bit_val;
    logic        bit_ack = 1'b0;
    logic        bit_rd = 1'b0;

    i2cm_engine dut (
        .clk, .rst_n,
        .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .rx_sel_i(rx_sel), .rx_word_o(rx_word),
        .pend_o(pend), .irq_o(irq),
        .bit_req_o(bit_req), .bit_op_o(bit_op), .bit_val_o(bit_val),
        .bit_ack_i(bit_ack), .bit_rd_i(bit_rd)
    );

    always #10 clk = ~clk;

    int checks = 0, fails = 0, cycles = 0;
    int log_op[512], log_val[512], log_n = 0;
    int exp_op[512], exp_val[512], exp_n = 0;
    int resp[512], rptr = 0, rfill = 0;
    logic [7:0] slave_rx[32];

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                fails++;
                $display("FAIL watchdog expired");
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    // bit-level timing generator and slave model
    initial begin
        int dly = 0;
        forever begin
            @(negedge clk);
            if (bit_ack) bit_ack = 1'b0;
            else if (bit_req) begin
                if (dly < 1) dly++;
                else begin
                    dly = 0;
                    log_op[log_n]  = int'(bit_op);
                    log_val[log_n] = int'(bit_val);
                    log_n++;
                    if (bit_op == 2'd2) begin
                        bit_rd = resp[rptr][0];
                        rptr++;
                    end
                    bit_ack = 1'b1;
                end
            end else dly = 0;
        end
    end

    task automatic wreg(input int a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic clr_log();
        log_n = 0; exp_n = 0; rptr = 0; rfill = 0;
    endtask

    task automatic e_bit(input int op, input int v);
        exp_op[exp_n] = op; exp_val[exp_n] = v; exp_n++;
    endtask

    task automatic e_wbyte(input logic [7:0] b, input int nak);
        for (int i = 7; i >= 0; i--) e_bit(1, int'(b[i]));
        e_bit(2, 0);
        resp[rfill] = nak; rfill++;
    endtask

    task automatic e_rbyte(input logic [7:0] b, input int ackv);
        for (int i = 7; i >= 0; i--) begin
            e_bit(2, 0);
            resp[rfill] = int'(b[i]); rfill++;
        end
        e_bit(1, ackv);
    endtask

    task automatic wait_pend(input logic [2:0] mask);
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if ((pend & mask) != 0) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic cmp_log(input string tag);
        int mism = 0;
        for (int i = 0; i < exp_n; i++)
            if (log_op[i] != exp_op[i] || (exp_op[i] == 1 && log_val[i] != exp_val[i]))
                mism++;
        chk(log_n == exp_n && mism == 0, tag, log_n * 1000 + mism, exp_n * 1000);
    endtask

    function automatic logic [7:0] txb(input int k);
        return 8'((k * 37 + 5) & 255);
    endfunction

    task automatic run_tx(input int n, input int st, input int nak_at, input int ab, input string tag);
        int m = (n > 32) ? 32 : n;
        bit stopped = 0;
        for (int w = 0; w < 8; w++)
            wreg(8 + w, {txb(4*w+3), txb(4*w+2), txb(4*w+1), txb(4*w)});
        wreg(0, 32'(1 | (st << 3) | (ab << 5)));
        clr_log();
        if (st != 0) e_bit(0, 0);
        for (int k = 0; k < m && !stopped; k++) begin
            e_wbyte(txb(k), (k == nak_at) ? 1 : 0);
            if (ab != 0 && k == nak_at) stopped = 1;
        end
        wreg(3, 32'(n));
        wait_pend(3'b101);
        cmp_log(tag);
        chk(pend == (stopped ? 3'b100 : 3'b001), tag, int'(pend), stopped ? 4 : 1);
        wreg(6, 32'h7);
    endtask

    task automatic run_rd(input int mode, input int rc, input int n, input int ln, input string tag);
        for (int k = 0; k < 32; k++) slave_rx[k] = 8'((k * 53 + 11 + n) & 255);
        wreg(0, 32'(1 | (mode << 1) | (ln << 4) | (1 << 5)));
        wreg(1, 32'h1A3);
        wreg(2, 32'((rc << 24) | 32'h3C2D1E));
        clr_log();
        if (mode == 1) begin
            e_bit(0, 0);
            if (rc > 0) begin
                e_wbyte(8'hA2, 0);
                for (int r = 0; r < rc; r++) e_wbyte(8'((32'h3C2D1E >> (8*r)) & 255), 0);
                e_bit(0, 0);
            end
            e_wbyte(8'hA3, 0);
        end
        for (int k = 0; k < n; k++) e_rbyte(slave_rx[k], (k == n-1) ? ln : 0);
        wreg(4, 32'(n));
        wait_pend(3'b110);
        cmp_log(tag);
        chk(pend == 3'b010, tag, int'(pend), 2);
        for (int w = 0; w < (n + 3) / 4; w++) begin
            logic [31:0] ex = '0, mask = '0;
            @(negedge clk);
            rx_sel = 3'(w);
            #1;
            for (int j = 0; j < 4; j++)
                if (4*w + j < n) begin
                    ex[8*j +: 8] = slave_rx[4*w + j];
                    mask[8*j +: 8] = 8'hFF;
                end
            chk((rx_word & mask) == ex, {tag, " rx word"}, int'(rx_word & mask), int'(ex));
        end
        wreg(6, 32'h7);
    endtask

    initial begin
        int hits;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(pend == 3'b000, "R1 pend", int'(pend), 0);
        chk(irq == 1'b0, "R1 irq", int'(irq), 0);
        chk(bit_req == 1'b0, "R1 req", int'(bit_req), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(pend == 3'b000 && !bit_req, "R1 after release", int'(pend), 0);

        // R2 count sweep with START (R3), plus clamp
        for (int n = 1; n <= 32; n++) run_tx(n, 1, 99, 1, "R2 tx sweep");
        run_tx(40, 1, 99, 1, "R2 clamp 40");
        // R3 no START when bit clear
        run_tx(3, 0, 99, 1, "R3 no start");
        // R8 abort on NACK, R9 continue without abort
        run_tx(5, 1, 1, 1, "R8 nak abort");
        run_tx(5, 1, 1, 0, "R9 nak ignored");
        run_tx(4, 1, 0, 1, "R8 nak on first byte");

        // R4 register-read sweep over register-address lengths, R7 final NACK
        for (int rc = 0; rc < 4; rc++) begin
            run_rd(1, rc, 1, 1, "R4 trx n1");
            run_rd(1, rc, 6, 1, "R4 trx n6");
        end
        run_rd(1, 2, 32, 1, "R4 trx full");
        // R6 continuation, R7 final ACK
        run_rd(2, 0, 5, 0, "R6 R7 cont ack");
        // R12 hold after non-last chunk
        hits = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (bit_req) hits++;
        end
        chk(hits == 0, "R12 hold", hits, 0);
        run_rd(2, 0, 9, 1, "R6 R7 cont nack");

        // R5 invalid read address blocks launch
        wreg(0, 32'h3);
        wreg(1, 32'h0A3);
        clr_log();
        wreg(4, 32'd4);
        repeat (60) @(negedge clk);
        chk(log_n == 0 && pend == 3'b000, "R5 invalid addr", log_n, 0);

        // R11 interrupt gating and clear
        run_tx(1, 1, 99, 1, "R11 setup");
        wreg(0, 32'h1);
        clr_log();
        wreg(3, 32'd1);
        wait_pend(3'b001);
        chk(irq == 1'b0, "R11 no enable", int'(irq), 0);
        wreg(5, 32'h2);
        chk(irq == 1'b0, "R11 wrong enable", int'(irq), 0);
        wreg(5, 32'h1);
        chk(irq == 1'b1, "R11 enabled", int'(irq), 1);
        wreg(6, 32'h1);
        chk(pend == 3'b000 && irq == 1'b0, "R11 w1c", int'(pend), 0);
        wreg(5, 32'h0);

        // R10 disable mid-chunk
        wreg(0, 32'h9);
        clr_log();
        wreg(3, 32'd10);
        repeat (40) @(negedge clk);
        wreg(0, 32'h0);
        repeat (3) @(negedge clk);
        hits = log_n;
        chk(bit_req == 1'b0, "R10 req dropped", int'(bit_req), 0);
        wreg(3, 32'd2);
        repeat (60) @(negedge clk);
        chk(log_n == hits && pend == 3'b000, "R10 stays off", log_n, hits);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule